// File: doc/BRIEF.md
# ALU Power-Gating Controller

This controller decides, at the end of every decision period, how many of a group of ALUs stay powered and which of them are gated. Each cycle it receives the number of instructions ready to issue. It caps that number at the issue width and adds every `SAMPLE_DIV`-th value into a windowed accumulator. When a window closes, the total is latched as the demand figure for that window.

At each decision point the latched demand is compared against a set of ascending, writable thresholds. The comparison gives the number of ALUs that must stay on. The rest are gated, and the units chosen are those reporting the highest leakage codes. The resulting mask is registered and held unchanged until the next decision point. The power switches, the wake-up sequencing and the leakage sensors sit outside this block.

Top module: `alu_gate_ctrl`

## Requirements
- R1: The ready count on `rdy_cnt_i` is capped at `ISSUE_MAX` (4 by default) before it is summed, so any larger value adds exactly `ISSUE_MAX`.
- R2: Within each `WINDOW_LEN`-cycle window, one capped count is added every `SAMPLE_DIV` cycles. At the end of the window the sum of those `WINDOW_LEN/SAMPLE_DIV` samples is latched and the accumulator restarts from zero.
- R3: The window accumulator saturates at 2^`SUM_W`-1 and never wraps.
- R4: The number of ALUs kept on is one plus the number of thresholds that the latched window sum strictly exceeds. A sum equal to a threshold does not count as exceeding it.
- R5: Threshold k (index 0 lowest) resets to field k of `THR_DEF` (133, 233, 333 by default). While `thr_we_i` is 1 at a clock edge, threshold `thr_sel_i` is loaded from `thr_wdata_i`.
- R6: The gated ALUs are the ones with the highest leakage codes. The code of ALU n+1 is `leak_i[LEAK_W*n +: LEAK_W]`. When two codes are equal, the ALU with the higher index is gated first.
- R7: Bit n of `gate_mask_o` belongs to ALU n+1, and a 1 means gated. At least one ALU is always left on.
- R8: `gate_mask_o` changes only on the clock edge that ends a `PERIOD`-cycle decision period, counted from reset release. That decision uses the most recently latched window sum and the leakage codes present in that cycle.
- R9: After reset `gate_mask_o` is 0000 (all ALUs on) until the first decision point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_cnt_i | input | CNT_W | Instructions ready to issue this cycle |
| leak_i | input | NUM_ALU*LEAK_W | Per-ALU leakage codes, ALU1 in the low field |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_sel_i | input | SEL_W | Threshold index to write |
| thr_wdata_i | input | SUM_W | Threshold write value |
| gate_mask_o | output | NUM_ALU | Registered gate mask, 1 = gated |

## Verification
The main instance is built with a 16-cycle window sampled every 2 cycles (8 samples), a 6-bit sum, a 40-cycle decision period and thresholds 7, 15 and 23. With these values each steady ready count maps to a distinct demand figure. A decision happens every few dozen cycles, and writing a threshold of 32 separates a capped count from an uncapped one. A second instance with a 5-bit sum and a top threshold of 30 lets a full window of count 4 reach 32. That window must saturate to 31 instead of wrapping to zero, which shows whether the accumulator saturates.

// File: rtl/alu_gate_pkg.sv
package alu_gate_pkg;

  // unit j outranks unit i for gating: higher code, or equal code and higher index
  function automatic logic leak_outranks(input int unsigned code_j, input int unsigned code_i,
                                         input int unsigned idx_j, input int unsigned idx_i);
    return (code_j > code_i) || ((code_j == code_i) && (idx_j > idx_i));
  endfunction

endpackage

// File: rtl/alu_gate_window.sv
module alu_gate_window #(
  parameter int CNT_W      = 4,
  parameter int ISSUE_MAX  = 4,
  parameter int SAMPLE_DIV = 4,
  parameter int WINDOW_LEN = 512,
  parameter int SUM_W      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rdy_cnt_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int WIN_W = $clog2(WINDOW_LEN);

  logic [WIN_W-1:0] win_q;
  logic [SUM_W-1:0] acc_q, acc_nxt, sum_q;
  logic [CNT_W-1:0] cap_cnt;
  logic [SUM_W:0]   wide_sum;
  logic             take, last;

  assign take = (int'(win_q) % SAMPLE_DIV) == 0;
  assign last = (win_q == WIN_W'(WINDOW_LEN - 1));

  always_comb begin
    cap_cnt = (rdy_cnt_i > CNT_W'(ISSUE_MAX)) ? CNT_W'(ISSUE_MAX) : rdy_cnt_i;
    wide_sum = {1'b0, acc_q} + (SUM_W+1)'(cap_cnt);
    acc_nxt  = acc_q;
    if (take) acc_nxt = wide_sum[SUM_W] ? '1 : wide_sum[SUM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      acc_q <= '0;
      sum_q <= '0;
    end else begin
      win_q <= last ? '0 : win_q + 1'b1;
      if (last) begin
        sum_q <= acc_nxt;
        acc_q <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/alu_gate_select.sv
module alu_gate_select
  import alu_gate_pkg::*;
#(
  parameter int NUM_ALU = 4,
  parameter int LEAK_W  = 3,
  parameter int SUM_W   = 9
) (
  input  logic [SUM_W-1:0]               sum_i,
  input  logic [NUM_ALU-2:0][SUM_W-1:0]  thr_i,
  input  logic [NUM_ALU*LEAK_W-1:0]      leak_i,
  output logic [NUM_ALU-1:0]             mask_o
);
  localparam int CW = $clog2(NUM_ALU) + 1;

  logic [CW-1:0] n_over, n_gate;

  always_comb begin
    n_over = '0;
    for (int k = 0; k < NUM_ALU-1; k++)
      if (sum_i > thr_i[k]) n_over = n_over + 1'b1;
    n_gate = CW'(NUM_ALU-1) - n_over;
  end

  for (genvar i = 0; i < NUM_ALU; i++) begin : g_rank
    logic [CW-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < NUM_ALU; j++)
        if (j != i && leak_outranks(int'(leak_i[LEAK_W*j +: LEAK_W]),
                                    int'(leak_i[LEAK_W*i +: LEAK_W]), j, i))
          rank = rank + 1'b1;
    end
    assign mask_o[i] = (rank < n_gate);
  end
endmodule

// File: rtl/alu_gate_ctrl.sv
module alu_gate_ctrl #(
  parameter int NUM_ALU    = 4,
  parameter int CNT_W      = 4,
  parameter int ISSUE_MAX  = 4,
  parameter int LEAK_W     = 3,
  parameter int SAMPLE_DIV = 4,
  parameter int WINDOW_LEN = 512,
  parameter int SUM_W      = 9,
  parameter int PERIOD     = 10000,
  parameter logic [NUM_ALU-2:0][SUM_W-1:0] THR_DEF = {9'd333, 9'd233, 9'd133},
  localparam int SEL_W     = (NUM_ALU > 2) ? $clog2(NUM_ALU-1) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          rdy_cnt_i,
  input  logic [NUM_ALU*LEAK_W-1:0] leak_i,
  input  logic                      thr_we_i,
  input  logic [SEL_W-1:0]          thr_sel_i,
  input  logic [SUM_W-1:0]          thr_wdata_i,
  output logic [NUM_ALU-1:0]        gate_mask_o
);
  localparam int PER_W = $clog2(PERIOD);

  logic [SUM_W-1:0]              win_sum;
  logic [NUM_ALU-2:0][SUM_W-1:0] thr_q;
  logic [NUM_ALU-1:0]            sel_mask, mask_q;
  logic [PER_W-1:0]              per_q;
  logic                          decide;

  alu_gate_window #(
    .CNT_W(CNT_W), .ISSUE_MAX(ISSUE_MAX), .SAMPLE_DIV(SAMPLE_DIV),
    .WINDOW_LEN(WINDOW_LEN), .SUM_W(SUM_W)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_cnt_i(rdy_cnt_i), .sum_o(win_sum)
  );

  alu_gate_select #(
    .NUM_ALU(NUM_ALU), .LEAK_W(LEAK_W), .SUM_W(SUM_W)
  ) u_select (
    .sum_i(win_sum), .thr_i(thr_q), .leak_i(leak_i), .mask_o(sel_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_DEF;
    end else if (thr_we_i && (int'(thr_sel_i) < NUM_ALU-1)) begin
      thr_q[thr_sel_i] <= thr_wdata_i;
    end
  end

  assign decide = (per_q == PER_W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      mask_q <= '0;
    end else begin
      per_q <= decide ? '0 : per_q + 1'b1;
      if (decide) mask_q <= sel_mask;
    end
  end

  assign gate_mask_o = mask_q;
endmodule

// File: rtl/alu_gate_ctrl_chk.sv
module alu_gate_ctrl_chk
  import alu_gate_pkg::*;
#(
  parameter int NUM_ALU = 4,
  parameter int LEAK_W  = 3,
  parameter int PERIOD  = 10000
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_ALU*LEAK_W-1:0] leak_i,
  input logic [NUM_ALU-1:0]        gate_mask_o
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] chk_cnt;
  logic          tick, first_done;

  assign tick = (chk_cnt == PW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt    <= '0;
      first_done <= 1'b0;
    end else begin
      chk_cnt <= tick ? '0 : chk_cnt + 1'b1;
      if (tick) first_done <= 1'b1;
    end
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_mask_o) |-> $past(tick));

  // R7
  one_alu_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_mask_o) <= NUM_ALU-1);

  // R9
  reset_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_done |-> gate_mask_o == '0);

  for (genvar i = 0; i < NUM_ALU; i++) begin : g_pi
    for (genvar j = 0; j < NUM_ALU; j++) begin : g_pj
      if (i != j) begin : g_pair
        // R6
        leak_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ($past(tick) && gate_mask_o[i] && !gate_mask_o[j]) |->
            leak_outranks(int'($past(leak_i[LEAK_W*i +: LEAK_W])),
                          int'($past(leak_i[LEAK_W*j +: LEAK_W])), i, j));
      end
    end
  end
endmodule

bind alu_gate_ctrl alu_gate_ctrl_chk #(
  .NUM_ALU(NUM_ALU), .LEAK_W(LEAK_W), .PERIOD(PERIOD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .leak_i(leak_i), .gate_mask_o(gate_mask_o)
);

// File: tb/alu_gate_ctrl_tb_top.sv
module alu_gate_ctrl_tb_top;
  localparam int P = 40;
  localparam int SETTLE = 2*P + 2;

  typedef struct packed {
    logic [3:0]  rdy;
    logic [11:0] leak;   // {ALU4,ALU3,ALU2,ALU1}
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, {3'd1,3'd2,3'd3,3'd4}, 4'b0111, 4'd4},  // R4 sum 0
    '{4'd1, {3'd1,3'd2,3'd3,3'd4}, 4'b0011, 4'd4},  // R4 sum 8
    '{4'd2, {3'd1,3'd2,3'd3,3'd4}, 4'b0001, 4'd4},  // R4 sum 16
    '{4'd3, {3'd1,3'd2,3'd3,3'd4}, 4'b0000, 4'd7},  // R7 sum 24
    '{4'd1, {3'd5,3'd5,3'd5,3'd5}, 4'b1100, 4'd6},  // R6 all tied
    '{4'd2, {3'd2,3'd6,3'd6,3'd0}, 4'b0100, 4'd6},  // R6 tie ALU3/ALU2
    '{4'd0, {3'd2,3'd6,3'd6,3'd0}, 4'b1110, 4'd6},  // R6
    '{4'd4, {3'd0,3'd0,3'd0,3'd7}, 4'b0000, 4'd2}   // R2 8 samples of 4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rdy = '0;
  logic [11:0] leak = '0;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [5:0]  wdata = '0;
  logic [3:0]  mask, mask_sat;
  int          cyc;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  alu_gate_ctrl #(
    .NUM_ALU(4), .CNT_W(4), .ISSUE_MAX(4), .LEAK_W(3), .SAMPLE_DIV(2),
    .WINDOW_LEN(16), .SUM_W(6), .PERIOD(P), .THR_DEF({6'd23, 6'd15, 6'd7})
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rdy_cnt_i(rdy), .leak_i(leak),
    .thr_we_i(we), .thr_sel_i(sel), .thr_wdata_i(wdata), .gate_mask_o(mask)
  );

  alu_gate_ctrl #(
    .NUM_ALU(4), .CNT_W(4), .ISSUE_MAX(4), .LEAK_W(3), .SAMPLE_DIV(2),
    .WINDOW_LEN(16), .SUM_W(5), .PERIOD(P), .THR_DEF({5'd30, 5'd15, 5'd7})
  ) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_n), .rdy_cnt_i(rdy), .leak_i(leak),
    .thr_we_i(1'b0), .thr_sel_i(2'd0), .thr_wdata_i(5'd0), .gate_mask_o(mask_sat)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: mask actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [1:0] idx, input logic [5:0] val);
    @(negedge clk);
    we = 1'b1; sel = idx; wdata = val;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    leak = {3'd1, 3'd2, 3'd3, 3'd4};
    repeat (3) @(negedge clk);
    check(mask, 4'b0000, "R9 during reset");
    rst_n = 1'b1;
    repeat (P - 5) @(negedge clk);
    check(mask, 4'b0000, "R9 before first decision");

    for (int k = 0; k < 8; k++) begin
      rdy  = VECS[k].rdy;
      leak = VECS[k].leak;
      settle();
      check(mask, VECS[k].exp, $sformatf("R%0d vector %0d", VECS[k].req, k));
    end

    // R5: sum equal to a written threshold does not exceed it
    wr_thr(2'd1, 6'd16);
    rdy = 4'd2; leak = {3'd1, 3'd2, 3'd3, 3'd4};
    settle();
    check(mask, 4'b0011, "R5 written threshold, R4 equal sum");
    wr_thr(2'd1, 6'd15);

    // R1: capped count 4 gives 32, not above threshold 32
    wr_thr(2'd2, 6'd32);
    rdy = 4'd7;
    settle();
    check(mask, 4'b0001, "R1 count 7 capped");
    // R3: 5-bit sum saturates at 31 > 30
    check(mask_sat, 4'b0000, "R3 saturating sum");
    rdy = 4'd4;
    settle();
    check(mask, 4'b0001, "R1 count 4 at threshold");

    // R8: mask held between decisions
    while ((cyc % P) != 1) @(negedge clk);
    rdy = 4'd0;
    repeat (P - 4) @(negedge clk);
    check(mask, 4'b0001, "R8 held within period");
    settle();
    check(mask, 4'b0111, "R8 updated at decision");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule